// File: doc/BRIEF.md
# Radix-64 Redundant-Binary Partial-Product Generator

This block produces the partial-product rows of a signed radix-64 Booth multiplier. The signed multiplier operand is recoded into digits that each cover six bits, with values from -32 to +32. For every digit the block picks hard multiples of the signed multiplicand, combines them and hands the row downstream as a redundant-binary (RB) pair: a plus vector and a minus vector whose difference is the row's value. Because every row stays in RB form, no row ever needs a carry-propagate adder. An accumulation tree and an RB-to-binary converter placed after this block turn the rows into the product.

The 3X multiple is built as 4X minus X, so its plus vector is X shifted left by two and its minus vector is X: only wiring. Each digit magnitude is split into a high multiple from {0, 8X, 16X, 24X, 32X} and a signed low multiple from {-3X .. 4X}. 24X is the RB 3X pair shifted left by three. The two RB terms are merged by a carry-free RB adder whose logic depth does not depend on the width. A negative digit swaps the plus and minus vectors of its row. Row i is shifted left by 6·i bits. An optional output register adds one cycle of latency.

Top module: `rb_radix64_ppgen`

## Requirements
- R1: With multiplicand width N and multiplier width M, the block emits ROWS = ceil((M+1)/6) rows of P = N+M bits. Row i occupies bits [i*P +: P] of both pp_plus_o and pp_minus_o.
- R2: For all signed x_i and y_i, the sum over rows of (plus - minus), taken modulo 2^P and read as signed, equals x_i * y_i. This includes the most negative operands and all-ones operands.
- R3: Digit i equals -32*y[6i+5] + 16*y[6i+4] + 8*y[6i+3] + 4*y[6i+2] + 2*y[6i+1] + y[6i] + y[6i-1], with y[-1] = 0 and y sign-extended above bit M-1. Row i's value (plus - minus) mod 2^P equals digit_i * x * 2^(6i).
- R4: No bit position of any row has its plus bit and its minus bit both set.
- R5: A row whose digit is zero has all plus and minus bits at 0.
- R6: A row with digit -d is the row with digit +d for the same multiplicand, with the plus and minus vectors exchanged.
- R7: With REG_OUT = 1, rows and valid_o appear one clock after valid_i is sampled high. Rows hold their value while valid_i is low, and valid_o falls one clock after valid_i falls. An active-low asynchronous reset clears valid_o and both row buses. With REG_OUT = 0, rows and valid_o follow the inputs in the same cycle.
- R8: The low 6·i bits of row i are 0 in both vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands are valid this cycle |
| x_i | input | N | Signed multiplicand |
| y_i | input | M | Signed multiplier |
| valid_o | output | 1 | Rows are valid |
| pp_plus_o | output | ROWS*(N+M) | Plus vectors of all rows, row 0 in the low bits |
| pp_minus_o | output | ROWS*(N+M) | Minus vectors of all rows, row 0 in the low bits |

## Verification
Every cycle, the assertions check four things. The recoded high and low selections stay within their legal sets. The carry-free RB merge preserves the sum of its two inputs modulo 2^P and never yields a digit with both bits set. The output register follows valid_i with one cycle of latency and holds while valid_i is low. Only the bench's scenarios can show three other properties. The exhaustive 8x8 sweep shows that each row carries exactly digit_i*x*2^(6i) and that the rows add up to the product. The directed pairs of y = +d and y = -d show that negation is a pure plus/minus exchange.

// File: rtl/rbpp_pkg.sv
package rbpp_pkg;
  localparam int GROUP_BITS = 6;

  // Digit selection: hi_sel 0..4 -> {0,8X,16X,24X,32X}, lo term +/-{0..4}X
  typedef struct packed {
    logic       neg;
    logic [2:0] hi_sel;
    logic       lo_neg;
    logic [2:0] lo_mag;
  } digit_ctrl_t;

  function automatic int row_count(input int m);
    return (m + GROUP_BITS) / GROUP_BITS;
  endfunction
endpackage

// File: rtl/rb_r64_recoder.sv
module rb_r64_recoder
  import rbpp_pkg::*;
(
  input  logic [GROUP_BITS:0] grp_i,
  output digit_ctrl_t         ctrl_o
);
  logic [6:0] dval;
  logic       neg;
  logic [5:0] mag;
  logic [5:0] hsum;

  // signed 6-bit group plus the overlap bit, range -32..32
  assign dval = {grp_i[6], grp_i[6:1]} + {6'd0, grp_i[0]};
  assign neg  = dval[6];
  assign mag  = neg ? (~dval[5:0] + 6'd1) : dval[5:0];
  // mag = 8*hi + lo with lo in -3..4
  assign hsum = mag + 6'd3;

  assign ctrl_o.neg    = neg;
  assign ctrl_o.hi_sel = hsum[5:3];
  assign ctrl_o.lo_neg = (hsum[2:0] < 3'd3);
  assign ctrl_o.lo_mag = (hsum[2:0] < 3'd3) ? (3'd3 - hsum[2:0]) : (hsum[2:0] - 3'd3);

  always_comb begin
    if (!$isunknown(grp_i)) begin
      assert_digit_sel_range_R3: assert (ctrl_o.hi_sel <= 3'd4 && ctrl_o.lo_mag <= 3'd4)
        else $error("digit selection out of range");
    end
  end
endmodule

// File: rtl/rb_multiple_sel.sv
module rb_multiple_sel
  import rbpp_pkg::*;
#(
  parameter int N = 16,
  parameter int M = 16,
  localparam int P = N + M
) (
  input  logic [N-1:0] x_i,
  input  digit_ctrl_t  ctrl_i,
  output logic [P-1:0] hi_p_o,
  output logic [P-1:0] hi_m_o,
  output logic [P-1:0] lo_p_o,
  output logic [P-1:0] lo_m_o
);
  logic [P-1:0] xe;
  logic [P-1:0] lp, lm;

  assign xe = {{M{x_i[N-1]}}, x_i};

  always_comb begin
    unique case (ctrl_i.hi_sel)
      3'd1:    begin hi_p_o = xe << 3; hi_m_o = '0;      end
      3'd2:    begin hi_p_o = xe << 4; hi_m_o = '0;      end
      3'd3:    begin hi_p_o = xe << 5; hi_m_o = xe << 3; end // 24X = (4X-X)<<3
      3'd4:    begin hi_p_o = xe << 5; hi_m_o = '0;      end
      default: begin hi_p_o = '0;      hi_m_o = '0;      end
    endcase
  end

  always_comb begin
    unique case (ctrl_i.lo_mag)
      3'd1:    begin lp = xe;      lm = '0; end
      3'd2:    begin lp = xe << 1; lm = '0; end
      3'd3:    begin lp = xe << 2; lm = xe; end // 3X = 4X - X, wiring only
      3'd4:    begin lp = xe << 2; lm = '0; end
      default: begin lp = '0;      lm = '0; end
    endcase
  end

  assign lo_p_o = ctrl_i.lo_neg ? lm : lp;
  assign lo_m_o = ctrl_i.lo_neg ? lp : lm;
endmodule

// File: rtl/rb_cf_adder.sv
module rb_cf_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_p_i,
  input  logic [W-1:0] a_m_i,
  input  logic [W-1:0] b_p_i,
  input  logic [W-1:0] b_m_i,
  output logic [W-1:0] z_p_o,
  output logic [W-1:0] z_m_o
);
  logic [W:0]   t_pos, t_neg, lo_ok;
  logic [W-1:0] w_pos, w_neg;

  // lo_ok[i]: both digits at position i-1 are non-negative
  always_comb begin
    lo_ok[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      lo_ok[i+1] = !(a_m_i[i] && !a_p_i[i]) && !(b_m_i[i] && !b_p_i[i]);
    end
  end

  always_comb begin
    t_pos[0] = 1'b0;
    t_neg[0] = 1'b0;
    for (int i = 0; i < W; i++) begin
      int s;
      s = int'(a_p_i[i]) - int'(a_m_i[i]) + int'(b_p_i[i]) - int'(b_m_i[i]);
      t_pos[i+1] = 1'b0;
      t_neg[i+1] = 1'b0;
      w_pos[i]   = 1'b0;
      w_neg[i]   = 1'b0;
      case (s)
        2:  t_pos[i+1] = 1'b1;
        -2: t_neg[i+1] = 1'b1;
        1:  if (lo_ok[i]) begin t_pos[i+1] = 1'b1; w_neg[i] = 1'b1; end
            else w_pos[i] = 1'b1;
        -1: if (lo_ok[i]) w_neg[i] = 1'b1;
            else begin t_neg[i+1] = 1'b1; w_pos[i] = 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      int z;
      z = int'(w_pos[i]) - int'(w_neg[i]) + int'(t_pos[i]) - int'(t_neg[i]);
      z_p_o[i] = (z == 1);
      z_m_o[i] = (z == -1);
    end
  end

  always_comb begin
    if (!$isunknown({a_p_i, a_m_i, b_p_i, b_m_i})) begin
      assert_sum_preserved_R2: assert ((z_p_o - z_m_o) == (a_p_i - a_m_i + b_p_i - b_m_i))
        else $error("RB merge changed the value");
      assert_no_double_digit_R4: assert ((z_p_o & z_m_o) == '0)
        else $error("RB digit with both bits set");
    end
  end
endmodule

// File: rtl/rb_radix64_ppgen.sv
module rb_radix64_ppgen
  import rbpp_pkg::*;
#(
  parameter int N       = 16,
  parameter int M       = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int P      = N + M,
  localparam int ROWS   = row_count(M)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [N-1:0]    x_i,
  input  logic [M-1:0]    y_i,
  output logic            valid_o,
  output logic [ROWS*P-1:0] pp_plus_o,
  output logic [ROWS*P-1:0] pp_minus_o
);
  localparam int YW = ROWS * GROUP_BITS;

  logic [YW:0]       y_ext;
  logic [ROWS*P-1:0] plus_c, minus_c;

  // sign-extend to full groups; implicit 0 below the LSB
  assign y_ext = {{(YW-M){y_i[M-1]}}, y_i, 1'b0};

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    digit_ctrl_t  ctrl;
    logic [P-1:0] hi_p, hi_m, lo_p, lo_m, sum_p, sum_m;

    rb_r64_recoder u_rec (
      .grp_i  (y_ext[GROUP_BITS*i +: GROUP_BITS+1]),
      .ctrl_o (ctrl)
    );

    rb_multiple_sel #(.N(N), .M(M)) u_sel (
      .x_i    (x_i),
      .ctrl_i (ctrl),
      .hi_p_o (hi_p),
      .hi_m_o (hi_m),
      .lo_p_o (lo_p),
      .lo_m_o (lo_m)
    );

    rb_cf_adder #(.W(P)) u_add (
      .a_p_i (hi_p),
      .a_m_i (hi_m),
      .b_p_i (lo_p),
      .b_m_i (lo_m),
      .z_p_o (sum_p),
      .z_m_o (sum_m)
    );

    // negation is a plus/minus exchange
    assign plus_c[i*P +: P]  = (ctrl.neg ? sum_m : sum_p) << (GROUP_BITS*i);
    assign minus_c[i*P +: P] = (ctrl.neg ? sum_p : sum_m) << (GROUP_BITS*i);
  end

  if (REG_OUT) begin : g_reg
    logic              valid_q;
    logic [ROWS*P-1:0] plus_q, minus_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        plus_q  <= '0;
        minus_q <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) begin
          plus_q  <= plus_c;
          minus_q <= minus_c;
        end
      end
    end

    assign valid_o    = valid_q;
    assign pp_plus_o  = plus_q;
    assign pp_minus_o = minus_q;

    assert_valid_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o) else $error("valid_o did not follow valid_i");
    assert_valid_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o) else $error("valid_o stayed high");
    assert_rows_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(pp_plus_o) && $stable(pp_minus_o)))
      else $error("rows changed without valid_i");
  end else begin : g_comb
    assign valid_o    = valid_i;
    assign pp_plus_o  = plus_c;
    assign pp_minus_o = minus_c;
  end
endmodule

// File: tb/rb_radix64_ppgen_bench.sv
module rb_radix64_ppgen_bench;
  localparam int TN = 8;
  localparam int TM = 8;
  localparam int TP = TN + TM;
  localparam int TR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [TN-1:0] xin = '0;
  logic [TM-1:0] yin = '0;
  logic vo_r, vo_c;
  logic [TR*TP-1:0] rp_r, rm_r, rp_c, rm_c;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rb_radix64_ppgen #(.N(TN), .M(TM), .REG_OUT(1'b1)) u_rb_radix64_ppgen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .x_i(xin), .y_i(yin),
    .valid_o(vo_r), .pp_plus_o(rp_r), .pp_minus_o(rm_r)
  );

  rb_radix64_ppgen #(.N(TN), .M(TM), .REG_OUT(1'b0)) u_rb_radix64_ppgen_comb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .x_i(xin), .y_i(yin),
    .valid_o(vo_c), .pp_plus_o(rp_c), .pp_minus_o(rm_c)
  );

  // digit per R3, with y sign-extended and y[-1] = 0
  function automatic int digit_of(input int yv, input int i);
    int lo, grp;
    lo  = (i == 0) ? 0 : ((yv >>> (6*i - 1)) & 1);
    grp = (yv >>> (6*i)) & 63;
    return ((grp >= 32) ? grp - 64 : grp) + lo;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
    end
  endtask

  task automatic check_rows(input logic [TR*TP-1:0] pl, input logic [TR*TP-1:0] mi,
                            input int xv, input int yv, input string tag);
    logic [TP-1:0] tot, rp, rm, diff, ev, mask;
    int d;
    tot = '0;
    for (int i = 0; i < TR; i++) begin
      rp   = pl[i*TP +: TP];
      rm   = mi[i*TP +: TP];
      diff = rp - rm;
      d    = digit_of(yv, i);
      ev   = TP'(d * xv * (1 << (6*i)));
      chk(diff == ev, "R3", $sformatf("%s row%0d x=%0d y=%0d", tag, i, xv, yv), diff, ev);
      chk((rp & rm) == '0, "R4", $sformatf("%s row%0d", tag, i), rp & rm, 0);
      mask = TP'((1 << (6*i)) - 1);
      chk(((rp | rm) & mask) == '0, "R8", $sformatf("%s row%0d", tag, i), (rp | rm) & mask, 0);
      if (d == 0) chk((rp | rm) == '0, "R5", $sformatf("%s row%0d", tag, i), rp | rm, 0);
      tot = tot + diff;
    end
    // R1 R2: rows at their slots sum to the product
    chk(tot == TP'(xv * yv), "R2", $sformatf("%s R1 sum x=%0d y=%0d", tag, xv, yv),
        tot, TP'(xv * yv));
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int px, py;
    logic [TP-1:0] p0, m0;
    int xs [5] = '{1, -1, 37, -128, 127};

    // reset state, R7
    #1;
    chk(vo_r == 1'b0, "R7", "reset valid_o", vo_r, 0);
    chk(rp_r == '0 && rm_r == '0, "R7", "reset rows", rp_r | rm_r, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    px = 0; py = 0;
    for (int xi = -128; xi < 128; xi++) begin
      for (int yi = -128; yi < 128; yi++) begin
        @(negedge clk);
        xin = TN'(xi);
        yin = TM'(yi);
        vld = 1'b1;
        #1;
        check_rows(rp_c, rm_c, xi, yi, "comb");
        chk(vo_c == 1'b1, "R7", "comb valid_o", vo_c, 1);
        if (xi != -128 || yi != -128) check_rows(rp_r, rm_r, px, py, "reg-latency R7");
        @(posedge clk);
        #1;
        check_rows(rp_r, rm_r, xi, yi, "reg");
        chk(vo_r == 1'b1, "R7", "reg valid_o", vo_r, 1);
        px = xi; py = yi;
      end
    end

    // valid low: registered rows hold, valid_o falls (R7)
    @(negedge clk);
    vld = 1'b0;
    xin = TN'(5);
    yin = TM'(7);
    @(posedge clk);
    #1;
    chk(vo_r == 1'b0, "R7", "valid_o after drop", vo_r, 0);
    chk(vo_c == 1'b0, "R7", "comb valid_o after drop", vo_c, 0);
    check_rows(rp_r, rm_r, px, py, "hold R7");

    // negation by exchange, R6
    foreach (xs[k]) begin
      for (int d = 1; d < 32; d++) begin
        @(negedge clk);
        vld = 1'b1;
        xin = TN'(xs[k]);
        yin = TM'(d);
        #1;
        p0 = rp_c[TP-1:0];
        m0 = rm_c[TP-1:0];
        yin = TM'(-d);
        #1;
        chk(rp_c[TP-1:0] == m0 && rm_c[TP-1:0] == p0, "R6",
            $sformatf("swap x=%0d d=%0d", xs[k], d), {rp_c[TP-1:0], rm_c[TP-1:0]}, {m0, p0});
      end
    end

    // asynchronous reset mid-run, R7
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk(vo_r == 1'b0, "R7", "async reset valid_o", vo_r, 0);
    chk(rp_r == '0 && rm_r == '0, "R7", "async reset rows", rp_r | rm_r, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog got running exp finished");
      summary();
      $finish;
    end
  end
endmodule